// File: doc/BRIEF.md
# Ring Instruction Distributor with Recycle Buffer

This block feeds one instruction stream to four SIMD cores that are linked in a ring. Each core is a group of four processing elements out of sixteen. A loop is launched with a start pulse that carries a base address, a body length and an iteration count. The sequencer then steps through the body once per iteration. Each issued instruction is loaded into the register of core 0. From there it moves one core further on every clock. As a result, core k runs the same stream k cycles after core 0, and successive iterations travel along the ring staggered in time.

Instruction memory is read at most once per issued instruction and never once per core. On the first pass of a loop, the last core of the ring records each instruction it receives in a 16-entry recycle buffer. When the body fits in that buffer, later passes take every instruction that has already been recorded from the buffer and leave memory idle. A body too long for the buffer is fetched from memory on every pass, and an overflow flag reports this. A new start pulse drops anything still in flight on the ring and empties the buffer.

Instruction memory is modelled as a combinational read: the word at `mem_addr` is returned on `mem_rdata` in the same cycle.

Top module: `ring_instr_dist`

## Requirements
- R1: While reset is applied and after it is released, with no loop started, all `core_valid` bits are 0, `mem_req` is 0 and `ovf_flag` is 0.
- R2: A `loop_start` pulse in cycle S with nonzero `loop_len` and `loop_iters` produces the following timing. Instruction j of pass p is issued in cycle S+1+p*len+j. Core 0 presents that instruction one cycle after it is issued.
- R3: Each ring hop takes exactly one cycle. Core k shows the same instruction that core k-1 showed in the previous cycle, with its valid bit set.
- R4: During the first pass, every issue is a memory read with `mem_req`=1 and `mem_addr` = base + j.
- R5: This requirement covers a body of 16 instructions or fewer, in pass p≥1.
  - Instruction j is replayed from the buffer, with `mem_req`=0, when p*len ≥ 5. This is the number of cycles from issue until the last core has recorded the instruction.
  - Otherwise it is fetched again from base + j.
- R6: A body longer than 16 sets `ovf_flag` from the cycle after the start pulse until the next start pulse. Every issue of that loop is a memory read.
- R7: Each core receives exactly len*iters instructions. In every pass, instruction j equals the memory word at base + j.
- R8: A `loop_start` during a running loop has two effects.
  - In the following cycle no core is valid.
  - The recycle buffer is emptied, so the new loop's replays only ever return the new loop's instructions.
- R9: A start pulse with `loop_len`=0 or `loop_iters`=0 issues nothing: there are no memory reads and no valid core.
- R10: `mem_addr` = base + j wraps modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loop_start | input | 1 | Pulse that launches a loop and flushes ring and buffer |
| loop_base | input | ADDR_W | Address of the first body instruction |
| loop_len | input | 8 | Body length in instructions |
| loop_iters | input | ITER_W | Number of passes over the body |
| mem_req | output | 1 | Instruction memory read strobe |
| mem_addr | output | ADDR_W | Instruction memory read address |
| mem_rdata | input | 32 | Word returned for `mem_addr`, same cycle |
| core_valid | output | NUM_CORES | Per-core instruction valid |
| core_instr | output | NUM_CORES x 32 | Per-core instruction |
| ovf_flag | output | 1 | The body does not fit in the recycle buffer |

## Verification
Two events can fall in the same cycle:
- the last core writing entry j into the recycle buffer;
- the sequencer deciding whether to replay that entry in its next pass.

Bodies of 2, 4 and 5 instructions put the replay decision exactly one cycle before, at, or after the write becomes visible. The bench predicts for each cycle, from p*len ≥ 5, whether `mem_req` must be low. It also compares every core's instruction with the memory word, so a replay taken too early shows up as a wrong instruction. A second collision is a start pulse landing while the ring and the buffer still hold an older loop. It is judged by the empty ring in the following cycle and by the new loop's replayed words.

// File: rtl/rd_pkg.sv
package rd_pkg;
  localparam int INSTR_W = 32;
  localparam int IDX_W   = 8;

  typedef struct packed {
    logic              valid;
    logic              first;
    logic              fits;
    logic [IDX_W-1:0]  idx;
    logic [INSTR_W-1:0] instr;
  } slot_t;
endpackage

// File: rtl/rd_rst_sync.sv
module rd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/rd_hop.sv
module rd_hop
  import rd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  flush,
  input  slot_t d,
  output slot_t q
);
  logic  vld_d, vld_q;
  slot_t pay_q;

  assign vld_d = d.valid && !flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  // payload: clock-enabled, no reset needed
  always_ff @(posedge clk) begin
    if (vld_d) pay_q <= d;
  end

  always_comb begin
    q       = pay_q;
    q.valid = vld_q;
  end
endmodule

// File: rtl/rd_rbuf.sv
module rd_rbuf
  import rd_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               wr_en,
  input  logic [INSTR_W-1:0] wr_data,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [INSTR_W-1:0] rd_data,
  output logic [CNT_W-1:0]   cnt
);
  logic [INSTR_W-1:0] store_q [DEPTH];
  logic [CNT_W-1:0]   cnt_d, cnt_q;
  logic               do_wr;

  assign do_wr = wr_en && !clear && (cnt_q < CNT_W'(DEPTH));

  always_comb begin
    cnt_d = cnt_q;
    if (clear)      cnt_d = '0;
    else if (do_wr) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // entries arrive in body order, so the fill count is the write pointer
  always_ff @(posedge clk) begin
    if (do_wr) store_q[cnt_q[PTR_W-1:0]] <= wr_data;
  end

  assign rd_data = store_q[rd_idx[PTR_W-1:0]];
  assign cnt     = cnt_q;
endmodule

// File: rtl/rd_seq.sv
module rd_seq
  import rd_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int ITER_W    = 8,
  parameter int BUF_DEPTH = 16,
  parameter int CNT_W     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loop_start,
  input  logic [ADDR_W-1:0] loop_base,
  input  logic [IDX_W-1:0]  loop_len,
  input  logic [ITER_W-1:0] loop_iters,
  input  logic [CNT_W-1:0]  buf_cnt,
  output logic              issue_valid,
  output logic              issue_replay,
  output logic              issue_first,
  output logic              issue_fits,
  output logic [IDX_W-1:0]  issue_idx,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              ovf_flag
);
  logic              act_d, act_q;
  logic [IDX_W-1:0]  idx_d, idx_q;
  logic [ITER_W-1:0] pass_d, pass_q;
  logic [IDX_W-1:0]  len_d, len_q;
  logic [ITER_W-1:0] iters_d, iters_q;
  logic [ADDR_W-1:0] base_d, base_q;
  logic              fits_d, fits_q;
  logic              ovf_d, ovf_q;

  always_comb begin
    act_d   = act_q;
    idx_d   = idx_q;
    pass_d  = pass_q;
    len_d   = len_q;
    iters_d = iters_q;
    base_d  = base_q;
    fits_d  = fits_q;
    ovf_d   = ovf_q;
    if (loop_start) begin
      act_d   = (loop_len != '0) && (loop_iters != '0);
      idx_d   = '0;
      pass_d  = '0;
      len_d   = loop_len;
      iters_d = loop_iters;
      base_d  = loop_base;
      fits_d  = loop_len <= IDX_W'(BUF_DEPTH);
      ovf_d   = loop_len >  IDX_W'(BUF_DEPTH);
    end else if (act_q) begin
      if (idx_q == len_q - 1'b1) begin
        idx_d = '0;
        if (pass_q == iters_q - 1'b1) act_d  = 1'b0;
        else                          pass_d = pass_q + 1'b1;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      idx_q   <= '0;
      pass_q  <= '0;
      len_q   <= '0;
      iters_q <= '0;
      base_q  <= '0;
      fits_q  <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      act_q   <= act_d;
      idx_q   <= idx_d;
      pass_q  <= pass_d;
      len_q   <= len_d;
      iters_q <= iters_d;
      base_q  <= base_d;
      fits_q  <= fits_d;
      ovf_q   <= ovf_d;
    end
  end

  // an issue in the cycle of a new start would be flushed anyway: drop it
  assign issue_valid  = act_q && !loop_start;
  assign issue_replay = issue_valid && fits_q && (pass_q != '0)
                        && (IDX_W'(buf_cnt) > idx_q);
  assign issue_first  = (pass_q == '0);
  assign issue_fits   = fits_q;
  assign issue_idx    = idx_q;
  assign mem_req      = issue_valid && !issue_replay;
  assign mem_addr     = base_q + ADDR_W'(idx_q);
  assign ovf_flag     = ovf_q;
endmodule

// File: rtl/ring_instr_dist.sv
module ring_instr_dist
  import rd_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int BUF_DEPTH = 16,
  parameter int ADDR_W    = 16,
  parameter int ITER_W    = 8,
  localparam int CNT_W    = $clog2(BUF_DEPTH + 1)
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                loop_start,
  input  logic [ADDR_W-1:0]                   loop_base,
  input  logic [IDX_W-1:0]                    loop_len,
  input  logic [ITER_W-1:0]                   loop_iters,
  output logic                                mem_req,
  output logic [ADDR_W-1:0]                   mem_addr,
  input  logic [INSTR_W-1:0]                  mem_rdata,
  output logic [NUM_CORES-1:0]                core_valid,
  output logic [NUM_CORES-1:0][INSTR_W-1:0]   core_instr,
  output logic                                ovf_flag
);
  logic               rst_int_n;
  logic               issue_valid, issue_replay, issue_first, issue_fits;
  logic [IDX_W-1:0]   issue_idx;
  logic [CNT_W-1:0]   buf_cnt;
  logic [INSTR_W-1:0] buf_rdata;
  logic               buf_wr;
  slot_t              issue_slot;
  slot_t              ring [NUM_CORES];

  rd_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  rd_seq #(
    .ADDR_W    (ADDR_W),
    .ITER_W    (ITER_W),
    .BUF_DEPTH (BUF_DEPTH),
    .CNT_W     (CNT_W)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .loop_start   (loop_start),
    .loop_base    (loop_base),
    .loop_len     (loop_len),
    .loop_iters   (loop_iters),
    .buf_cnt      (buf_cnt),
    .issue_valid  (issue_valid),
    .issue_replay (issue_replay),
    .issue_first  (issue_first),
    .issue_fits   (issue_fits),
    .issue_idx    (issue_idx),
    .mem_req      (mem_req),
    .mem_addr     (mem_addr),
    .ovf_flag     (ovf_flag)
  );

  always_comb begin
    issue_slot.valid = issue_valid;
    issue_slot.first = issue_first;
    issue_slot.fits  = issue_fits;
    issue_slot.idx   = issue_idx;
    issue_slot.instr = issue_replay ? buf_rdata : mem_rdata;
  end

  for (genvar k = 0; k < NUM_CORES; k++) begin : g_hop
    if (k == 0) begin : g_head
      rd_hop u_hop (
        .clk   (clk),
        .rst_n (rst_int_n),
        .flush (loop_start),
        .d     (issue_slot),
        .q     (ring[k])
      );
    end else begin : g_link
      rd_hop u_hop (
        .clk   (clk),
        .rst_n (rst_int_n),
        .flush (loop_start),
        .d     (ring[k-1]),
        .q     (ring[k])
      );
    end
  end

  // only the first pass of a fitting body is recorded by the tail core
  assign buf_wr = ring[NUM_CORES-1].valid && ring[NUM_CORES-1].first
                  && ring[NUM_CORES-1].fits;

  rd_rbuf #(
    .DEPTH (BUF_DEPTH)
  ) u_rbuf (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .clear   (loop_start),
    .wr_en   (buf_wr),
    .wr_data (ring[NUM_CORES-1].instr),
    .rd_idx  (issue_idx),
    .rd_data (buf_rdata),
    .cnt     (buf_cnt)
  );

  always_comb begin
    for (int k = 0; k < NUM_CORES; k++) begin
      core_valid[k] = ring[k].valid;
      core_instr[k] = ring[k].instr;
    end
  end
endmodule

// File: rtl/ring_instr_dist_chk.sv
module ring_instr_dist_chk
  import rd_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int BUF_DEPTH = 16,
  parameter int ADDR_W    = 16,
  parameter int ITER_W    = 8
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic                              loop_start,
  input logic [ADDR_W-1:0]                 loop_base,
  input logic [IDX_W-1:0]                  loop_len,
  input logic [ITER_W-1:0]                 loop_iters,
  input logic                              mem_req,
  input logic [ADDR_W-1:0]                 mem_addr,
  input logic [NUM_CORES-1:0]              core_valid,
  input logic [NUM_CORES-1:0][INSTR_W-1:0] core_instr,
  input logic                              ovf_flag
);
  p_first_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_start && loop_len != '0 && loop_iters != '0)
      |=> (mem_req && mem_addr == $past(loop_base)));

  for (genvar k = 1; k < NUM_CORES; k++) begin : g_hop_chk
    p_hop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (core_valid[k-1] && !loop_start)
        |=> (core_valid[k] && core_instr[k] == $past(core_instr[k-1])));
  end

  p_ovf_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    loop_start |=> (ovf_flag == ($past(loop_len) > IDX_W'(BUF_DEPTH))));

  p_ovf_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_start |=> $stable(ovf_flag));

  p_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    loop_start |=> (core_valid == '0));

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_start && (loop_len == '0 || loop_iters == '0)) |=> !mem_req);
endmodule

bind ring_instr_dist ring_instr_dist_chk #(
  .NUM_CORES (NUM_CORES),
  .BUF_DEPTH (BUF_DEPTH),
  .ADDR_W    (ADDR_W),
  .ITER_W    (ITER_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_int_n),
  .loop_start (loop_start),
  .loop_base  (loop_base),
  .loop_len   (loop_len),
  .loop_iters (loop_iters),
  .mem_req    (mem_req),
  .mem_addr   (mem_addr),
  .core_valid (core_valid),
  .core_instr (core_instr),
  .ovf_flag   (ovf_flag)
);

// File: tb/ring_instr_dist_tb_top.sv
module ring_instr_dist_tb_top;
  localparam int NC = 4;
  localparam int DEPTH = 16;
  localparam int AW = 16;
  localparam int IW = 8;
  localparam int REPLAY_LAG = 5;

  logic                    clk;
  logic                    rst_n;
  logic                    loop_start;
  logic [AW-1:0]           loop_base;
  logic [7:0]              loop_len;
  logic [IW-1:0]           loop_iters;
  logic                    mem_req;
  logic [AW-1:0]           mem_addr;
  logic [31:0]             mem_rdata;
  logic [NC-1:0]           core_valid;
  logic [NC-1:0][31:0]     core_instr;
  logic                    ovf_flag;

  int n_cmp = 0;
  int n_bad = 0;

  function automatic logic [31:0] mem_word(input logic [AW-1:0] a);
    return {a ^ 16'h5A5A, ~a};
  endfunction

  assign mem_rdata = mem_word(mem_addr);

  ring_instr_dist #(
    .NUM_CORES (NC),
    .BUF_DEPTH (DEPTH),
    .ADDR_W    (AW),
    .ITER_W    (IW)
  ) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .loop_start (loop_start),
    .loop_base  (loop_base),
    .loop_len   (loop_len),
    .loop_iters (loop_iters),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rdata  (mem_rdata),
    .core_valid (core_valid),
    .core_instr (core_instr),
    .ovf_flag   (ovf_flag)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string rq, input logic [63:0] got, input logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", rq, got, exp, $time);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic do_start(input logic [AW-1:0] b, input int len, input int it);
    @(negedge clk);
    loop_base  = b;
    loop_len   = 8'(len);
    loop_iters = IW'(it);
    loop_start = 1'b1;
    @(negedge clk);
    loop_start = 1'b0;
  endtask

  // cycle-by-cycle comparison from the cycle after the start pulse
  task automatic check_run(input string rq, input logic [AW-1:0] b, input int len, input int it);
    int total = len * it;
    bit fits  = (len <= DEPTH);
    int mem_reads = 0;
    int exp_reads = 0;
    for (int n = 0; n < total + NC + 2; n++) begin
      bit exp_req = 0;
      int j = 0;
      if (n > 0) @(negedge clk);
      #1;
      if (n == 0) chk({rq, " R6 ovf_flag"}, 64'(ovf_flag), 64'(len > DEPTH));
      if (n < total) begin
        int p = n / len;
        j = n % len;
        exp_req = !(fits && p >= 1 && p * len >= REPLAY_LAG);
      end
      if (exp_req) exp_reads++;
      if (mem_req) mem_reads++;
      chk({rq, " R5 mem_req"}, 64'(mem_req), 64'(exp_req));
      if (exp_req && mem_req)
        chk({rq, " R4 mem_addr"}, 64'(mem_addr), 64'(AW'(b + AW'(j))));
      for (int k = 0; k < NC; k++) begin
        int q = n - 1 - k;
        bit exp_v = (q >= 0) && (q < total);
        chk({rq, " R2 core_valid"}, 64'(core_valid[k]), 64'(exp_v));
        if (exp_v && core_valid[k])
          chk({rq, (k == 0) ? " R7 core_instr" : " R3 core_instr"},
              64'(core_instr[k]), 64'(mem_word(AW'(b + AW'(q % len)))));
      end
    end
    chk({rq, " R5 read count"}, 64'(mem_reads), 64'(exp_reads));
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", 64'(core_valid), 64'(0));
    chk("R1 req in reset", 64'(mem_req), 64'(0));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 valid after reset", 64'(core_valid), 64'(0));
    chk("R1 req after reset", 64'(mem_req), 64'(0));
    chk("R1 ovf after reset", 64'(ovf_flag), 64'(0));
  endtask

  task automatic t_basic();
    do_start(16'h0100, 8, 3);
    check_run("R2 basic", 16'h0100, 8, 3);
  endtask

  task automatic t_boundaries();
    do_start(16'h0200, 5, 3);
    check_run("R5 len5", 16'h0200, 5, 3);
    do_start(16'h0300, 4, 3);
    check_run("R5 len4", 16'h0300, 4, 3);
    do_start(16'h0400, 2, 5);
    check_run("R5 len2", 16'h0400, 2, 5);
    do_start(16'h0500, 1, 7);
    check_run("R5 len1", 16'h0500, 1, 7);
    do_start(16'h0600, 16, 2);
    check_run("R5 len16", 16'h0600, 16, 2);
  endtask

  task automatic t_overflow();
    do_start(16'h0700, 17, 2);
    check_run("R6 len17", 16'h0700, 17, 2);
    do_start(16'h0800, 3, 2);
    check_run("R6 flag cleared", 16'h0800, 3, 2);
  endtask

  task automatic t_restart();
    do_start(16'h0900, 6, 4);
    repeat (8) @(negedge clk);
    do_start(16'h0A00, 6, 3);
    check_run("R8 restart", 16'h0A00, 6, 3);
  endtask

  task automatic t_zero();
    do_start(16'h0B00, 0, 3);
    for (int n = 0; n < 6; n++) begin
      @(negedge clk);
      chk("R9 len0 req", 64'(mem_req), 64'(0));
      chk("R9 len0 valid", 64'(core_valid), 64'(0));
    end
    do_start(16'h0B00, 4, 0);
    for (int n = 0; n < 6; n++) begin
      @(negedge clk);
      chk("R9 iters0 req", 64'(mem_req), 64'(0));
      chk("R9 iters0 valid", 64'(core_valid), 64'(0));
    end
  endtask

  task automatic t_wrap();
    do_start(16'hFFFD, 6, 2);
    check_run("R10 wrap", 16'hFFFD, 6, 2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    rst_n      = 1'b0;
    loop_start = 1'b0;
    loop_base  = '0;
    loop_len   = '0;
    loop_iters = '0;
    t_reset();
    t_basic();
    t_boundaries();
    t_overflow();
    t_restart();
    t_zero();
    t_wrap();
    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule